// File: doc/BRIEF.md
# Word-Oriented SPI Master with Coded Clock Prescaler

This block is a full-duplex SPI master. A host reaches it through a small word-addressed register port. Each 32-bit word written to the data register is queued in a transmit FIFO. The shift engine takes words from that FIFO one at a time and sends each one out on MOSI. It samples MISO at the same time, and every complete received word is queued in a receive FIFO. The host empties the receive FIFO by reading the data register. Chip select is not tied to the shift engine: it is an output bit of a general-purpose register, so software can keep the slave selected across any number of words.

The serial clock is a power-of-two fraction of the block clock. The fraction is chosen by a 4-bit code that is split across two registers. The code-to-divisor mapping is not monotonic. A high-speed bit halves the serial clock half-period. A status register shows both FIFO empty flags, a 2-bit shifter state and a sticky completion interrupt flag.

Register word addresses: 0 = control (bit 4 enable, bits [1:0] code low), 1 = extended (bit 4 high-speed, bits [1:0] code high), 2 = status, 3 = data, 4 = GPIO (bit 0 drives `cs_n`, reset value 1).

Shifter states, named for the brief: IDLE (code 00) waits for a queued word. LOAD (01) spends one setup cycle after the word is taken. SHIFT (10) runs 32 SCK periods. STORE (11) pushes the received word. The transitions are IDLE→LOAD when the block is enabled and the transmit FIFO holds a word, LOAD→SHIFT unconditionally, SHIFT→STORE on the 32nd falling SCK edge, and STORE→IDLE unconditionally. Clearing the enable bit forces every state back to IDLE.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, status reads rx-empty (bit 0) = 1, tx-empty (bit 1) = 1, state (bits [3:2]) = 00 and interrupt (bit 7) = 0. `sck` is 0, `cs_n` is 1 and `irq` is 0.
- R2: The prescale code selects the SCK half-period in block clocks as follows: 0→1, 1→2, 2→4, 5→8, 3→16, 4→32, 6→64, 7→128, 8→256, 9→512, 10→1024, 11→2048.
- R3: Code bits [1:0] are control bits [1:0]. Code bits [3:2] are extended bits [1:0].
- R4: Words are sent MSB first in SPI mode 0. MOSI is stable before the first rising SCK edge and changes only after falling edges.
- R5: MISO is sampled on rising SCK edges, MSB first. Reading the data register returns the oldest received word.
- R6: Each FIFO holds 16 words. A data write while the transmit FIFO is full is dropped.
- R7: Reading the data register while the receive FIFO is empty returns 0.
- R8: While control bit 4 is 0, `sck` stays 0 and the state field reads 00, even when words are queued.
- R9: The state field is non-zero from the moment a word is taken until its received word has been stored.
- R10: Status bit 7 and `irq` set when a word completes with the transmit FIFO empty. Writing 1 to status bit 7 clears them.
- R11: When extended bit 4 is 1, the half-period is halved, with a minimum of 1.
- R12: GPIO register bit 0 drives `cs_n` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which also serves as the prescaler base |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select from GPIO bit 0 |
| irq | output | 1 | Completion interrupt flag |

## Verification
A wrong prescale decode changes the measured SCK pulse width on the very first pulse of a transfer. A shifter state that skips a step or repeats a bit makes the loopback or slave-pattern word come back rotated or bit-shifted at the next data read. A FIFO pointer or count error appears within one 17-word burst, as a missing, duplicated or non-zero word when the receive FIFO is drained. A flag that sets or clears at the wrong time is visible on `irq` and in status bit 7 within one cycle of the STORE→IDLE transition.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_SHIFT = 2'b10,
        ST_STORE = 2'b11
    } shift_state_t;

    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_EXT  = 1;
    localparam int unsigned REG_STAT = 2;
    localparam int unsigned REG_DATA = 3;
    localparam int unsigned REG_GPIO = 4;

    // Prescale code to log2 of half-period; codes above 11 clamp to the slowest.
    function automatic logic [3:0] code_to_log2(input logic [3:0] code);
        logic [3:0] lg;
        unique case (code)
            4'd3:    lg = 4'd4;
            4'd4:    lg = 4'd5;
            4'd5:    lg = 4'd3;
            4'd12, 4'd13, 4'd14, 4'd15: lg = 4'd11;
            default: lg = code;
        endcase
        return lg;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign level   = cnt;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_host_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    input  logic       fast,
    output logic       tick
);
    logic [3:0]       lg, lg_eff;
    logic [CNT_W-1:0] half_len, cnt;

    always_comb begin
        lg       = code_to_log2(code);
        lg_eff   = (fast && lg != 4'd0) ? lg - 4'd1 : lg;
        half_len = CNT_W'(1) << lg_eff;
    end

    assign tick = run && (cnt == half_len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_host_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              tick,
    output logic              run,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output shift_state_t      state
);
    localparam int unsigned BW = $clog2(WORD_W);

    shift_state_t      st_q, st_d;
    logic [WORD_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic              rx_bit_q, sck_q;
    logic              last_fall;

    assign last_fall = tick && sck_q && (bit_q == BW'(WORD_W-1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (!tx_empty) st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_SHIFT;
            ST_SHIFT: if (last_fall) st_d = ST_STORE;
            ST_STORE: st_d = ST_IDLE;
        endcase
        if (!enable) st_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            bit_q    <= '0;
            rx_bit_q <= 1'b0;
            sck_q    <= 1'b0;
        end else if (!enable) begin
            sck_q <= 1'b0;
            bit_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (!tx_empty) sh_q <= tx_word;
                ST_LOAD: begin
                    bit_q <= '0;
                    sck_q <= 1'b0;
                end
                ST_SHIFT: if (tick) begin
                    if (!sck_q) begin
                        sck_q    <= 1'b1;
                        rx_bit_q <= miso;
                    end else begin
                        sck_q <= 1'b0;
                        sh_q  <= {sh_q[WORD_W-2:0], rx_bit_q};
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_STORE: ;
            endcase
        end
    end

    assign tx_pop  = enable && (st_q == ST_IDLE) && !tx_empty;
    assign run     = (st_q == ST_SHIFT);
    assign sck     = sck_q;
    assign mosi    = sh_q[WORD_W-1];
    assign rx_push = (st_q == ST_STORE);
    assign rx_word = sh_q;
    assign state   = st_q;
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
    import spi_host_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned DIV_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              irq
);
    localparam int unsigned LW = $clog2(FIFO_DEPTH+1);

    logic         ctl_en, ext_fast, irq_q, gpio_cs;
    logic [1:0]   code_lo, code_hi;
    logic         wr_stb, rd_stb;
    logic         tx_empty, tx_full, rx_empty, rx_full, tx_pop, rx_push, run, tick;
    logic [WORD_W-1:0] tx_word, rx_word, rx_head;
    logic [LW-1:0] tx_level, rx_level;
    shift_state_t state;

    assign wr_stb = bus_sel && bus_wr;
    assign rd_stb = bus_sel && !bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            code_lo  <= '0;
            ext_fast <= 1'b0;
            code_hi  <= '0;
            gpio_cs  <= 1'b1;
            irq_q    <= 1'b0;
        end else begin
            if (wr_stb && bus_addr == 3'(REG_CTRL)) begin
                ctl_en  <= bus_wdata[4];
                code_lo <= bus_wdata[1:0];
            end
            if (wr_stb && bus_addr == 3'(REG_EXT)) begin
                ext_fast <= bus_wdata[4];
                code_hi  <= bus_wdata[1:0];
            end
            if (wr_stb && bus_addr == 3'(REG_GPIO)) gpio_cs <= bus_wdata[0];
            if (rx_push && tx_empty)                 irq_q <= 1'b1;
            else if (wr_stb && bus_addr == 3'(REG_STAT) && bus_wdata[7]) irq_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            3'(REG_CTRL): bus_rdata = WORD_W'({ctl_en, 2'b00, code_lo});
            3'(REG_EXT):  bus_rdata = WORD_W'({ext_fast, 2'b00, code_hi});
            3'(REG_STAT): bus_rdata = WORD_W'({irq_q, 3'b000, state, tx_empty, rx_empty});
            3'(REG_DATA): bus_rdata = rx_head;
            3'(REG_GPIO): bus_rdata = WORD_W'(gpio_cs);
            default:      bus_rdata = '0;
        endcase
    end

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst_n,
        .push (wr_stb && bus_addr == 3'(REG_DATA)),
        .din  (bus_wdata),
        .pop  (tx_pop),
        .dout (tx_word),
        .empty(tx_empty),
        .full (tx_full),
        .level(tx_level)
    );

    spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst_n,
        .push (rx_push),
        .din  (rx_word),
        .pop  (rd_stb && bus_addr == 3'(REG_DATA)),
        .dout (rx_head),
        .empty(rx_empty),
        .full (rx_full),
        .level(rx_level)
    );

    spi_clk_div #(.CNT_W(DIV_W)) u_div (
        .clk, .rst_n,
        .run  (run),
        .code ({code_hi, code_lo}),
        .fast (ext_fast),
        .tick (tick)
    );

    spi_shift_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk, .rst_n,
        .enable  (ctl_en),
        .tx_empty(tx_empty),
        .tx_word (tx_word),
        .tx_pop  (tx_pop),
        .tick    (tick),
        .run     (run),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .rx_push (rx_push),
        .rx_word (rx_word),
        .state   (state)
    );

    assign cs_n = gpio_cs;
    assign irq  = irq_q;
endmodule

// File: rtl/spi_host_ctl_chk.sv
module spi_host_ctl_chk #(
    parameter int unsigned LW    = 5,
    parameter int unsigned DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_en,
    input logic          sck,
    input logic [1:0]    state,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          irq,
    input logic          rx_push,
    input logic          clr_req
);
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH)); // R6
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH)); // R6
    AST_SCK_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !sck); // R8
    AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b00) |-> !sck); // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !rx_push) |=> !irq); // R10
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state) == 2'b11); // R10
endmodule

bind spi_host_ctl spi_host_ctl_chk #(.LW(LW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_en   (ctl_en),
    .sck      (sck),
    .state    (state),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .irq      (irq),
    .rx_push  (rx_push),
    .clr_req  (bus_sel && bus_wr && bus_addr == 3'd2 && bus_wdata[7])
);

// File: tb/test_spi_host_ctl.sv
`timescale 1ns/1ps
module test_spi_host_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso, cs_n, irq;

    logic        loop_mode = 1'b1;
    logic [31:0] slv_sh = '0;
    logic [31:0] mosi_cap = '0;
    int          n_chk = 0, n_bad = 0;
    int          wd = 0;

    always #2.5 clk = ~clk;

    assign miso = loop_mode ? mosi : slv_sh[31];
    always @(negedge sck) if (!loop_mode) slv_sh <= slv_sh << 1;
    always @(posedge sck) mosi_cap <= {mosi_cap[30:0], mosi};

    spi_host_ctl i_spi_host_ctl (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .sck, .mosi, .miso, .cs_n, .irq
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd2, s);
            if (s[1] && s[3:2] == 2'b00) return;
        end
    endtask

    task automatic drain();
        logic [31:0] s, d;
        for (int i = 0; i < 20; i++) begin
            rd(3'd2, s);
            if (s[0]) return;
            rd(3'd3, d);
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(3'd2, s);
        chk(s[7:0] == 8'h03, "R1 status", s, 32'h3);
        chk(sck == 0 && cs_n == 1 && irq == 0, "R1 pins", {sck, cs_n, irq}, 3'b010);
    endtask

    task automatic t_div(input logic [3:0] code, input bit fast, input int exp, input string req);
        int n;
        wr(3'd0, {27'd0, 1'b1, 2'b00, code[1:0]});
        wr(3'd1, {27'd0, fast, 2'b00, code[3:2]});
        wr(3'd3, 32'h1234_5678);
        n = 0;
        for (int i = 0; i < 200 && !sck; i++) @(negedge clk);
        while (sck && n < 5000) begin n++; @(negedge clk); end
        chk(n == exp, req, n, exp);
        wait_idle();
        drain();
    endtask

    task automatic t_msb_loop();
        logic [31:0] d;
        loop_mode = 1'b1;
        wr(3'd0, 32'h11); wr(3'd1, 32'h0);
        mosi_cap = '0;
        wr(3'd3, 32'hA5C3_0F81);
        wait_idle();
        chk(mosi_cap == 32'hA5C3_0F81, "R4 mosi order", mosi_cap, 32'hA5C3_0F81);
        rd(3'd3, d);
        chk(d == 32'hA5C3_0F81, "R5 loopback", d, 32'hA5C3_0F81);
    endtask

    task automatic t_slave();
        logic [31:0] d;
        loop_mode = 1'b0;
        slv_sh = 32'h9E37_79B9;
        wr(3'd0, 32'h10); wr(3'd1, 32'h0);
        wr(3'd3, 32'h0);
        wait_idle();
        rd(3'd3, d);
        chk(d == 32'h9E37_79B9, "R5 slave word", d, 32'h9E37_79B9);
        loop_mode = 1'b1;
    endtask

    task automatic t_fifo();
        logic [31:0] d, s;
        wr(3'd0, 32'h00);
        for (int k = 0; k < 17; k++) wr(3'd3, 32'h100 + k);
        wr(3'd0, 32'h10);
        wait_idle();
        for (int k = 0; k < 16; k++) begin
            rd(3'd3, d);
            chk(d == 32'h100 + k, "R6 fifo order", d, 32'h100 + k);
        end
        rd(3'd3, d);
        chk(d == 32'h0, "R6 R7 dropped word / empty read", d, 0);
        rd(3'd2, s);
        chk(s[0] == 1'b1, "R7 rx empty", s, 1);
    endtask

    task automatic t_gate();
        logic [31:0] s, d;
        bit seen = 0;
        wr(3'd0, 32'h00);
        wr(3'd3, 32'hCAFE_F00D);
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (sck) seen = 1; end
        chk(!seen, "R8 sck held", seen, 0);
        rd(3'd2, s);
        chk(s[3:2] == 2'b00 && s[1] == 1'b0, "R8 state idle with data", s[3:0], 4'b0001);
        wr(3'd0, 32'h12);
        repeat (4) @(negedge clk);
        rd(3'd2, s);
        chk(s[3:2] != 2'b00, "R9 busy state", s[3:2], 2'b10);
        wait_idle();
        rd(3'd3, d);
        chk(d == 32'hCAFE_F00D, "R9 completed after enable", d, 32'hCAFE_F00D);
    endtask

    task automatic t_irq();
        logic [31:0] s;
        wr(3'd2, 32'h80);
        rd(3'd2, s);
        chk(s[7] == 0 && irq == 0, "R10 cleared", s[7], 0);
        wr(3'd0, 32'h10);
        wr(3'd3, 32'h5);
        wait_idle();
        rd(3'd2, s);
        chk(s[7] == 1 && irq == 1, "R10 set on done", {irq, s[7]}, 2'b11);
        wr(3'd2, 32'h80);
        chk(irq == 0, "R10 write-one clear", irq, 0);
        drain();
    endtask

    task automatic t_gpio();
        logic [31:0] d;
        wr(3'd4, 32'h0);
        chk(cs_n == 0, "R12 cs low", cs_n, 0);
        rd(3'd4, d);
        chk(d == 32'h0, "R12 readback", d, 0);
        wr(3'd4, 32'h1);
        chk(cs_n == 1, "R12 cs high", cs_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_div(4'd0, 1'b0, 1, "R2 code0 half=1");
        t_div(4'd5, 1'b0, 8, "R2 R3 code5 half=8");
        t_div(4'd3, 1'b0, 16, "R2 R3 code3 half=16");
        t_div(4'd4, 1'b0, 32, "R2 R3 code4 half=32");
        t_div(4'd5, 1'b1, 4, "R11 fast code5 half=4");
        t_div(4'd0, 1'b1, 1, "R11 fast code0 half=1");
        t_msb_loop();
        t_slave();
        t_fifo();
        t_gate();
        t_irq();
        t_gpio();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule